// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Unit

This block gathers eight interrupt sources into one sticky status register and one software-written mask register, and raises a single request line toward the CPU. Four sources are external pins that signal an interrupt by falling from high to low. They are first brought into the clock domain by a flop chain, then edge-detected. The other four are one-cycle event strobes from on-chip peripherals: a timer rollover, two counter events and a demodulator "byte received" strobe.

Software reads the status register to find which sources are pending. It clears a flag by writing 0 to its bit; a 1 in the write data leaves the flag as it is. The mask register selects which pending flags may drive the request, and a global enable gates the request as a whole. Vector generation and priority handling are left to the CPU.

Top module: `irqf_unit`

## Requirements
- R1: Status bit positions are fixed: bit 0 timer rollover, bit 1 external pin 0, bit 2 external pin 1, bit 3 external pin 2, bit 4 counter-1 event, bit 5 counter-2 event, bit 6 demodulator data, bit 7 external pin 3. A 1 means pending.
- R2: A high-to-low transition on an external pin sets its flag on the third rising clock edge after the pin changes (two synchroniser flops plus one edge-history flop). Rising edges and steady levels set nothing.
- R3: An internal event input that is high at a rising clock edge sets its flag at that edge.
- R4: A status write clears each flag whose write-data bit is 0 and leaves each flag whose write-data bit is 1 unchanged.
- R5: When a source event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: With no event and no clearing write, each flag keeps its value.
- R7: A mask write loads the write data into the mask register on the next edge, and the mask reads back unchanged. Status writes do not alter the mask.
- R8: The request output is high exactly when the global enable is high and at least one flag is set whose mask bit is 1.
- R9: Reset clears status and mask and holds the request low. A pin held low through reset and after it sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 4 | External interrupt pins, active on falling edge |
| tmr_ovf_i | input | 1 | Timer rollover strobe |
| cnt1_evt_i | input | 1 | Counter-1 event strobe |
| cnt2_evt_i | input | 1 | Counter-2 event strobe |
| demod_evt_i | input | 1 | Demodulator data-ready strobe |
| glb_en_i | input | 1 | Global request enable |
| stat_wr_i | input | 1 | Status write strobe (write-0-to-clear) |
| mask_wr_i | input | 1 | Mask write strobe |
| wdata_i | input | 8 | Write data for status or mask |
| stat_o | output | 8 | Status flags |
| mask_o | output | 8 | Mask register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its defaults: four external pins and a synchroniser depth of two. At that depth the edge-to-flag latency is three edges, which the directed pin tests measure cycle by cycle. The random phase toggles pins at a low rate, so falls, rises and pulses of one or two cycles all pass through the synchroniser. It also fires internal strobes while writes are under way, which often makes an event and a clearing write hit the same bit in one cycle.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int NUM_SRC = 8;
    localparam int NUM_EXT = 4;

    localparam int POS_TMR  = 0;
    localparam int POS_EXT0 = 1;
    localparam int POS_EXT1 = 2;
    localparam int POS_EXT2 = 3;
    localparam int POS_CNT1 = 4;
    localparam int POS_CNT2 = 5;
    localparam int POS_DEM  = 6;
    localparam int POS_EXT3 = 7;

    typedef logic [NUM_SRC-1:0] flags_t;

    function automatic int ext_pos(input int idx);
        case (idx)
            0:       return POS_EXT0;
            1:       return POS_EXT1;
            2:       return POS_EXT2;
            default: return POS_EXT3;
        endcase
    endfunction

endpackage

// File: rtl/irqf_edge_sync.sv
module irqf_edge_sync #(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] fall_o
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   last;
    } sync_t;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        sync_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.sh   = {st_q.sh[SYNC_STAGES-2:0], pin_i[g]};
            st_d.last = st_q.sh[TOP];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign fall_o[g] = st_q.last & ~st_q.sh[TOP];

        // R2: an edge pulse lasts one cycle only
        a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o[g] |=> !fall_o[g]);
    end

endmodule

// File: rtl/irqf_src_map.sv
module irqf_src_map
    import irqf_pkg::*;
(
    input  logic [NUM_EXT-1:0] ext_fall_i,
    input  logic               tmr_ovf_i,
    input  logic               cnt1_evt_i,
    input  logic               cnt2_evt_i,
    input  logic               demod_evt_i,
    output flags_t             set_o
);

    always_comb begin
        set_o           = '0;
        set_o[POS_TMR]  = tmr_ovf_i;
        set_o[POS_CNT1] = cnt1_evt_i;
        set_o[POS_CNT2] = cnt2_evt_i;
        set_o[POS_DEM]  = demod_evt_i;
        for (int i = 0; i < NUM_EXT; i++) begin
            set_o[ext_pos(i)] = ext_fall_i[i];
        end
    end

endmodule

// File: rtl/irqf_status_reg.sv
module irqf_status_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] stat_o
);

    typedef struct packed {
        logic [WIDTH-1:0] flags;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        if (wr_i) st_d.flags = st_q.flags & wdata_i;
        st_d.flags = st_d.flags | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.flags;

    for (genvar b = 0; b < WIDTH; b++) begin : g_chk
        a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> stat_o[b]);
        a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && !wdata_i[b] && !set_i[b]) |=> !stat_o[b]);
        a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && !wdata_i[b] && set_i[b]) |=> stat_o[b]);
        a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[b] && !(wr_i && !wdata_i[b])) |=> $stable(stat_o[b]));
    end

endmodule

// File: rtl/irqf_unit.sv
module irqf_unit
    import irqf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic               tmr_ovf_i,
    input  logic               cnt1_evt_i,
    input  logic               cnt2_evt_i,
    input  logic               demod_evt_i,
    input  logic               glb_en_i,
    input  logic               stat_wr_i,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] stat_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);

    typedef struct packed {
        flags_t mask;
    } ctl_t;

    logic [NUM_EXT-1:0] ext_fall;
    flags_t             set_vec;
    flags_t             stat;
    ctl_t               ctl_d, ctl_q;

    irqf_edge_sync #(
        .NUM_PINS   (NUM_EXT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (ext_irq_i),
        .fall_o(ext_fall)
    );

    irqf_src_map u_map (
        .ext_fall_i (ext_fall),
        .tmr_ovf_i  (tmr_ovf_i),
        .cnt1_evt_i (cnt1_evt_i),
        .cnt2_evt_i (cnt2_evt_i),
        .demod_evt_i(demod_evt_i),
        .set_o      (set_vec)
    );

    irqf_status_reg #(
        .WIDTH(NUM_SRC)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .wr_i   (stat_wr_i),
        .wdata_i(wdata_i),
        .stat_o (stat)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (mask_wr_i) ctl_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign stat_o = stat;
    assign mask_o = ctl_q.mask;
    assign irq_o  = glb_en_i & (|(stat & ctl_q.mask));

    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_o == $past(wdata_i)));
    a_r7_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_o));
    a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |-> !irq_o);
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);

endmodule

// File: tb/tb_irqf_unit.sv
`timescale 1ns/1ps
module tb_irqf_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_irq = '0;
    logic       tmr = 0, c1 = 0, c2 = 0, dem = 0, glb = 0, swr = 0, mwr = 0;
    logic [7:0] wdata = '0;
    logic [7:0] stat_o, mask_o;
    logic       irq_o;

    int n_chk = 0, n_fail = 0;
    logic [7:0] e_stat = '0, e_mask = '0;
    logic [3:0] hA = '0, hB = '0, hC = '0;

    always #4 clk = ~clk;

    irqf_unit dut (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .tmr_ovf_i(tmr),
        .cnt1_evt_i(c1), .cnt2_evt_i(c2), .demod_evt_i(dem), .glb_en_i(glb),
        .stat_wr_i(swr), .mask_wr_i(mwr), .wdata_i(wdata),
        .stat_o(stat_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    function automatic int pin_bit(input int k);
        return (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : 7;
    endfunction

    function automatic logic [7:0] events(input logic [3:0] falls);
        logic [7:0] v = '0;
        v[0] = tmr; v[4] = c1; v[5] = c2; v[6] = dem;
        for (int k = 0; k < 4; k++) v[pin_bit(k)] = falls[k];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one clock cycle with the inputs as currently driven; ends at a negedge
    task automatic cyc();
        logic [7:0] ns;
        ns = swr ? (e_stat & wdata) : e_stat;
        ns = ns | events(hC & ~hB);
        if (mwr) e_mask = wdata;
        e_stat = ns;
        @(posedge clk);
        hC = hB; hB = hA; hA = ext_irq;
        @(negedge clk);
        chk("R6 status", stat_o, e_stat);
        chk("R7 mask", mask_o, e_mask);
        chk("R8 irq", {7'b0, irq_o}, {7'b0, glb & (|(e_stat & e_mask))});
    endtask

    task automatic wr_stat(input logic [7:0] v);
        swr = 1; wdata = v; cyc(); swr = 0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: tmr = 1;
            1: c1 = 1;
            2: c2 = 1;
            default: dem = 1;
        endcase
        cyc();
        tmr = 0; c1 = 0; c2 = 0; dem = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R9 reset stat", stat_o, 8'h00);
        chk("R9 reset mask", mask_o, 8'h00);
        chk("R9 reset irq", {7'b0, irq_o}, 8'h00);
        repeat (5) cyc();
        chk("R9 low pins no flag", stat_o, 8'h00);

        // internal sources, fixed positions
        pulse(0); chk("R3 timer", stat_o, 8'h01); chk("R1 timer bit0", stat_o, 8'h01); wr_stat(8'h00);
        pulse(1); chk("R1 cnt1 bit4", stat_o, 8'h10); wr_stat(8'h00);
        pulse(2); chk("R1 cnt2 bit5", stat_o, 8'h20); wr_stat(8'h00);
        pulse(3); chk("R1 demod bit6", stat_o, 8'h40); wr_stat(8'h00);

        // external pins: rise ignored, fall lands on third edge
        for (int k = 0; k < 4; k++) begin
            ext_irq[k] = 1'b1;
            repeat (5) cyc();
            chk("R2 rise ignored", stat_o, 8'h00);
            ext_irq[k] = 1'b0;
            cyc(); cyc();
            chk("R2 not yet", stat_o, 8'h00);
            cyc();
            chk("R2 fall sets", stat_o, 8'h01 << pin_bit(k));
            chk("R1 pin position", stat_o, 8'h01 << pin_bit(k));
            wr_stat(8'h00);
        end

        // write-0-to-clear, write-1-keeps
        pulse(0); pulse(1); pulse(2); pulse(3);
        chk("R6 sticky", stat_o, 8'h71);
        wr_stat(8'hF0);
        chk("R4 partial clear", stat_o, 8'h70);

        // event beats clear
        c1 = 1; wr_stat(8'h00); c1 = 0;
        chk("R5 event wins", stat_o, 8'h10);

        // mask and request
        mwr = 1; wdata = 8'hA5; cyc(); mwr = 0;
        chk("R7 mask load", mask_o, 8'hA5);
        wr_stat(8'hFF);
        chk("R7 mask unaffected", mask_o, 8'hA5);
        glb = 1; cyc();
        chk("R8 unmasked flag only", {7'b0, irq_o}, 8'h00);
        mwr = 1; wdata = 8'h10; cyc(); mwr = 0;
        chk("R8 request high", {7'b0, irq_o}, 8'h01);
        glb = 0; #1;
        chk("R8 global off", {7'b0, irq_o}, 8'h00);
        cyc();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            tmr = ($urandom_range(0, 15) == 0);
            c1  = ($urandom_range(0, 15) == 0);
            c2  = ($urandom_range(0, 15) == 0);
            dem = ($urandom_range(0, 15) == 0);
            for (int k = 0; k < 4; k++)
                if ($urandom_range(0, 3) == 0) ext_irq[k] = ~ext_irq[k];
            swr = ($urandom_range(0, 5) == 0);
            mwr = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 19) == 0) glb = ~glb;
            wdata = 8'($urandom);
            cyc();
        end
        tmr = 0; c1 = 0; c2 = 0; dem = 0; swr = 0; mwr = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule